// File: doc/BRIEF.md
# Store Buffer with Youngest-Match Search

This block holds processor stores that are waiting to be written into an L1 data cache. Each store is kept as an address/data word pair in a four-slot circular array. Every store from the processor goes into the buffer and never to the cache directly. When all slots are occupied, the store port drops its ready signal.

A load presents its address on the lookup port. In the same cycle the block reports whether any buffered store targets that address, and with what data, so the cache can be probed in parallel. When several buffered stores share the address, the data from the one inserted last is returned.

In the background the oldest entry is shown on the drain port. It retires when the downstream side signals that it is idle and no processor request is using the cache in that cycle.

Top module: `store_buffer`

## Requirements
- R1: Entries retire strictly in insertion order, and the buffer never holds more than DEPTH (4) entries.
- R2: A store is accepted in a cycle where `st_valid` and `st_ready` are both 1. Every accepted store is later presented on the drain port with the address and data it had on entry.
- R3: With 4 entries held, `st_ready` is 0 unless a drain retires an entry in that same cycle. In that case `st_ready` is 1 and the store is accepted.
- R4: The lookup is combinational. `ld_hit` and `ld_data` reflect the current contents in the same cycle as `ld_addr`, and `ld_hit` is 0 when no held entry matches.
- R5: When several held entries match `ld_addr`, `ld_data` equals the data of the most recently inserted of them.
- R6: `dr_valid` is 1 exactly when the buffer is non-empty, and `dr_addr`/`dr_data` then show the oldest entry. The entry retires (`dr_ack` = 1) in a cycle where `dr_en` = 1 and `cpu_access` = 0.
- R7: In any cycle with `cpu_access` = 1, no entry retires (`dr_ack` = 0) and the drain port contents are unchanged by that cycle.
- R8: Matching compares all AW address bits. Addresses differing in any single bit, low or high, do not match.
- R9: In a cycle where a store is inserted or an entry retires, the lookup answers from the contents before that cycle's update.
- R10: While reset is asserted and after it is released, the buffer is empty: `dr_valid` = 0, `ld_hit` = 0, `st_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Processor store request |
| st_addr | input | AW | Store byte address (word aligned) |
| st_data | input | DW | Store data word |
| st_ready | output | 1 | Store can be accepted this cycle |
| ld_addr | input | AW | Load lookup address |
| ld_hit | output | 1 | A held entry matches `ld_addr` |
| ld_data | output | DW | Data of the youngest matching entry |
| dr_en | input | 1 | Downstream cache idle and able to take an entry |
| cpu_access | input | 1 | Processor request uses the cache this cycle |
| dr_valid | output | 1 | Oldest entry present |
| dr_addr | output | AW | Address of the oldest entry |
| dr_data | output | DW | Data of the oldest entry |
| dr_ack | output | 1 | Oldest entry retires at the coming edge |

## Verification
The bench fills the buffer with repeated stores to one address and checks that a lookup picks the last one. A design that searched from the oldest slot, or that lost track of age once the pointers wrapped, would return stale data. It pushes into a full buffer both with and without a simultaneous drain. A design that ignored the freed slot would stall, and one that ignored fullness would overwrite the oldest entry. It also holds `cpu_access` high while `dr_en` is set and probes addresses that differ from held ones in a single low or high bit, which exposes a drain that ignores the priority input or a comparator that drops address bits. A long random phase over a small address set compares every output against a queue model each cycle. This covers pointer wraparound and lookups in the same cycle as a store or drain.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned SB_AW    = 32;
  localparam int unsigned SB_DW    = 32;
  localparam int unsigned SB_DEPTH = 4;
endpackage

// File: rtl/sb_ptr_ctrl.sv
module sb_ptr_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  logic [PW-1:0] head_nx, tail_nx;
  logic [CW-1:0] cnt_nx;

  always_comb begin
    head_nx = head;
    tail_nx = tail;
    cnt_nx  = cnt;
    if (pop)  head_nx = head + PW'(1);
    if (push) tail_nx = tail + PW'(1);
    if (push && !pop) cnt_nx = cnt + CW'(1);
    else if (pop && !push) cnt_nx = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else if (push || pop) begin
      head <= head_nx;
      tail <= tail_nx;
      cnt  <= cnt_nx;
    end
  end

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R1
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt != '0);
endmodule

// File: rtl/sb_entry_array.sv
module sb_entry_array #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [PW-1:0]             wr_idx,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic                      clr_en,
  input  logic [PW-1:0]             clr_idx,
  output logic [DEPTH-1:0]          valid,
  output logic [DEPTH-1:0][AW-1:0]  addr_q,
  output logic [DEPTH-1:0][DW-1:0]  data_q
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_here, clr_here, valid_nx;
    assign wr_here  = wr_en && (wr_idx == PW'(g));
    assign clr_here = clr_en && (clr_idx == PW'(g));

    always_comb begin
      valid_nx = valid[g];
      if (clr_here) valid_nx = 1'b0;
      if (wr_here)  valid_nx = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid[g] <= 1'b0;
      else if (wr_here || clr_here) valid[g] <= valid_nx;
    end

    always_ff @(posedge clk) begin
      if (wr_here) begin
        addr_q[g] <= wr_addr;
        data_q[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/sb_search.sv
module sb_search #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DEPTH-1:0]          valid,
  input  logic [DEPTH-1:0][AW-1:0]  addr_q,
  input  logic [DEPTH-1:0][DW-1:0]  data_q,
  input  logic [PW-1:0]             head,
  input  logic [AW-1:0]             key,
  output logic                      hit,
  output logic [DW-1:0]             hit_data
);
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = valid[g] && (addr_q[g] == key);
  end

  // Walk slots from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] idx;
      idx = head + PW'(k);
      if (match[idx]) begin
        hit      = 1'b1;
        hit_data = data_q[idx];
      end
    end
  end

  // R4
  empty_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid == '0) |-> !hit);
endmodule

// File: rtl/store_buffer.sv
module store_buffer
  import sb_pkg::*;
#(
  parameter int unsigned DEPTH = SB_DEPTH,
  parameter int unsigned AW = SB_AW,
  parameter int unsigned DW = SB_DW,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_ready,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  input  logic          dr_en,
  input  logic          cpu_access,
  output logic          dr_valid,
  output logic [AW-1:0] dr_addr,
  output logic [DW-1:0] dr_data,
  output logic          dr_ack
);
  logic [PW-1:0] head, tail;
  logic [CW-1:0] cnt;
  logic full, empty, push, pop;
  logic [DEPTH-1:0]         valid;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;

  assign pop      = !empty && dr_en && !cpu_access;
  assign st_ready = !full || pop;
  assign push     = st_valid && st_ready;

  sb_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .head(head), .tail(tail), .cnt(cnt), .full(full), .empty(empty)
  );

  sb_entry_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push), .wr_idx(tail), .wr_addr(st_addr), .wr_data(st_data),
    .clr_en(pop), .clr_idx(head),
    .valid(valid), .addr_q(addr_q), .data_q(data_q)
  );

  sb_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_search (
    .clk(clk), .rst_n(rst_n), .valid(valid), .addr_q(addr_q), .data_q(data_q),
    .head(head), .key(ld_addr), .hit(ld_hit), .hit_data(ld_data)
  );

  assign dr_valid = !empty;
  assign dr_addr  = addr_q[head];
  assign dr_data  = data_q[head];
  assign dr_ack   = pop;

  // R1
  valid_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid) == int'(cnt));

  // R7
  cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_access && dr_valid) |=> dr_valid && $stable(dr_addr) && $stable(dr_data));

  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> $stable(cnt));
endmodule

// File: tb/sim_store_buffer.sv
`timescale 1ns/1ps
module sim_store_buffer;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic st_valid, st_ready, ld_hit, dr_en, cpu_access, dr_valid, dr_ack;
  logic [AW-1:0] st_addr, ld_addr, dr_addr;
  logic [DW-1:0] st_data, ld_data, dr_data;

  always #2.5 clk = ~clk;

  store_buffer u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_ready(st_ready), .ld_addr(ld_addr), .ld_hit(ld_hit),
    .ld_data(ld_data), .dr_en(dr_en), .cpu_access(cpu_access),
    .dr_valid(dr_valid), .dr_addr(dr_addr), .dr_data(dr_data), .dr_ack(dr_ack)
  );

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } ent_t;
  ent_t model[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, compare after settling, update model at the rising edge.
  task automatic step(bit sv, logic [AW-1:0] sa, logic [DW-1:0] sd,
                      logic [AW-1:0] la, bit den, bit cpu, string tag);
    bit e_fire, e_ready, e_hit;
    logic [DW-1:0] e_ld;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; ld_addr = la;
    dr_en = den; cpu_access = cpu;
    #1;
    e_fire  = (model.size() > 0) && den && !cpu;
    e_ready = (model.size() < DEPTH) || e_fire;
    e_hit = 0; e_ld = '0;
    foreach (model[i]) if (model[i].a == la) begin e_hit = 1; e_ld = model[i].d; end
    chk({tag, " R3 st_ready"}, DW'(st_ready), DW'(e_ready));
    chk({tag, " R7 dr_ack"}, DW'(dr_ack), DW'(e_fire));
    chk({tag, " R6 dr_valid"}, DW'(dr_valid), DW'(model.size() > 0));
    if (model.size() > 0) begin
      chk({tag, " R1 dr_addr"}, dr_addr, model[0].a);
      chk({tag, " R2 dr_data"}, dr_data, model[0].d);
    end
    chk({tag, " R4 ld_hit"}, DW'(ld_hit), DW'(e_hit));
    if (e_hit) chk({tag, " R5 ld_data"}, ld_data, e_ld);
    @(posedge clk);
    if (e_fire) void'(model.pop_front());
    if (sv && e_ready) model.push_back('{a: sa, d: sd});
  endtask

  localparam logic [AW-1:0] A = 32'h0000_0100;
  localparam logic [AW-1:0] B = 32'h0000_0104;

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; st_valid = 0; st_addr = '0; st_data = '0; ld_addr = A;
    dr_en = 0; cpu_access = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset dr_valid", DW'(dr_valid), 0);
    chk("R10 reset ld_hit", DW'(ld_hit), 0);
    chk("R10 reset st_ready", DW'(st_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    step(0, '0, '0, A, 0, 0, "R10 after reset");
    // fill with repeated addresses: youngest must win
    step(1, A, 32'h11, A, 0, 0, "R9 store lookup same cycle");
    step(1, B, 32'h22, A, 0, 0, "R2 fill");
    step(1, A, 32'h33, A, 0, 0, "R9 fill");
    step(1, A, 32'h44, B, 0, 0, "R2 fill");
    step(0, '0, '0, A, 0, 0, "R5 youngest of three");
    // full: no drain -> rejected; drain with cpu access -> still rejected
    step(1, B, 32'h55, B, 1, 1, "R7 cpu blocks drain");
    step(1, B, 32'h66, B, 0, 0, "R3 full stall");
    // R8: single-bit differences
    step(0, '0, '0, A ^ 32'h4, 0, 0, "R8 bit2");
    step(0, '0, '0, A ^ 32'h8000_0000, 0, 0, "R8 bit31");
    step(0, '0, '0, A ^ 32'h1, 0, 0, "R8 bit0");
    // full with simultaneous drain: accepted
    step(1, B, 32'h77, B, 1, 0, "R3 push with drain");
    step(0, '0, '0, B, 0, 0, "R5 youngest B");
    // drain all in order
    for (int i = 0; i < 6; i++) step(0, '0, '0, A, 1, 0, "R1 drain");
    step(0, '0, '0, A, 1, 0, "R6 empty");
    // random phase over a small address set
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] pick [4] = '{A, B, 32'h0000_0108, 32'h8000_0100};
      step(bit'($urandom_range(0, 99) < 60), pick[$urandom_range(0, 3)], $urandom(),
           pick[$urandom_range(0, 3)], bit'($urandom_range(0, 99) < 45),
           bit'($urandom_range(0, 99) < 30), "R9 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule